// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block sits in the feedback path of a frequency synthesizer. It divides a fast input clock by either N or N+1, and it picks the modulus once for each divided-output period. The choice comes from one control bit. That bit is either an external bit stream, normally the output of a delta-sigma modulator, or the carry of a built-in first-order phase accumulator. The accumulator source is kept so that its periodic N/N+1 pattern can be compared with the randomised stream.

In accumulator mode the fractional word K is added once per output period into an AW-bit register. The carry stretches the next period by one input clock. The average ratio is therefore N + K/2^AW. For example, N = 278 with K = 19661 and AW = 16 gives about 278.3. The divided clock and a one-clock strobe mark each period. N, K, the source select and the control bit are all taken at the period boundary, so a period never changes length once it has started.

Top module: `fracdiv_top`

## Requirements
- R1: While reset is high, `div_stb` and `div_clk` are low and the accumulator is cleared. After reset is released, the first strobe appears max(N,2) input clocks later.
- R2: In external mode (`src_sel` = 0), a control value of 0 gives a period of N input clocks.
- R3: In external mode, a control value of 1 gives a period of N+1 input clocks.
- R4: The control bit is sampled only on the last input clock of a period, and it sets the length of the following period. Values it takes earlier in the period are ignored. A period's length is fixed once it starts.
- R5: In accumulator mode (`src_sel` = 1), K is added into an AW-bit accumulator at every period boundary. The carry out of that add selects N+1 for the next period, otherwise N. `mod_bit` is ignored in this mode.
- R6: `div_stb` is high for exactly one input clock per period, on the first clock of that period.
- R7: `div_clk` is high for the first ceil(L/2) clocks of a period of length L and low for the rest.
- R8: Changes to N, K or `src_sel` take effect at the next period boundary. They never affect the period in progress.
- R9: Values of N below 2 are treated as 2.
- R10: Starting from a cleared accumulator in accumulator mode, M consecutive periods span exactly M*N + floor(M*K/2^AW) input clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock that is divided |
| rst | input | 1 | Synchronous active-high reset |
| n_div | input | NW | Integer modulus N |
| k_frac | input | AW | Fractional word K for the accumulator |
| src_sel | input | 1 | Control source: 0 external bit, 1 internal accumulator |
| mod_bit | input | 1 | External modulus control bit (1 selects N+1) |
| div_clk | output | 1 | Divided clock, high for the first half of each period |
| div_stb | output | 1 | One-clock pulse at the start of each period |

## Verification
The hardest case to reach is a control input that changes inside a period while N, K and the source select change around it. Only the value present on the very last clock may count. The stimulus is driven from the bench's own model of the current period length. It toggles `mod_bit` randomly on every earlier clock and places the deciding value exactly on the final clock. New N, K and source values are applied on the first clock of a period, so the period in progress must keep its old length.

The long accumulator runs add the total clock counts over thousands of periods. Any single misplaced carry then shows up as a mismatch against the exact expected sum.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;
  typedef enum logic {
    CTL_EXTERNAL = 1'b0,
    CTL_ACCUM    = 1'b1
  } ctl_src_e;
endpackage

// File: rtl/fracdiv_accum.sv
module fracdiv_accum #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [AW-1:0] k_frac,
  output logic          carry
);
  logic [AW-1:0] acc;
  logic [AW:0]   sum;

  // phase sum for the add taken at the coming boundary
  assign sum   = {1'b0, acc} + {1'b0, k_frac};
  assign carry = sum[AW];

  always_ff @(posedge clk) begin
    if (rst)
      acc <= '0;
    else if (adv)
      acc <= sum[AW-1:0];
  end

  // R5
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(acc));
endmodule

// File: rtl/fracdiv_select.sv
module fracdiv_select
  import fracdiv_pkg::*;
#(
  parameter int NW = 12,
  localparam int LW = NW + 1
) (
  input  logic [NW-1:0] n_div,
  input  ctl_src_e      src,
  input  logic          ext_bit,
  input  logic          acc_carry,
  output logic [LW-1:0] base_len,
  output logic [LW-1:0] next_len
);
  logic ctl;

  always_comb begin
    // the counter needs at least two clocks per period
    if (n_div < NW'(2))
      base_len = LW'(2);
    else
      base_len = {1'b0, n_div};
    ctl      = (src == CTL_ACCUM) ? acc_carry : ext_bit;
    next_len = base_len + LW'(ctl);
  end
endmodule

// File: rtl/fracdiv_counter.sv
module fracdiv_counter #(
  parameter int LW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] base_len,
  input  logic [LW-1:0] next_len,
  output logic          wrap,
  output logic          div_clk,
  output logic          div_stb
);
  logic [LW-1:0] cnt, plen;
  logic [LW-1:0] cnt_n, plen_n, half_n;

  assign wrap = (cnt == plen - LW'(1));

  always_comb begin
    cnt_n  = wrap ? '0 : cnt + LW'(1);
    plen_n = wrap ? next_len : plen;
    half_n = (plen_n + LW'(1)) >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      plen    <= base_len;
      div_stb <= 1'b0;
      div_clk <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      plen    <= plen_n;
      div_stb <= wrap;
      div_clk <= (cnt_n < half_n);
    end
  end

  // R6
  stb_single_chk: assert property (@(posedge clk) disable iff (rst)
    div_stb |=> !div_stb);
  // R4
  len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(plen));
  // R7
  clk_at_start_chk: assert property (@(posedge clk) disable iff (rst)
    div_stb |-> div_clk);
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < plen);
  // R9
  len_min_chk: assert property (@(posedge clk) disable iff (rst)
    plen >= LW'(2));
endmodule

// File: rtl/fracdiv_top.sv
module fracdiv_top
  import fracdiv_pkg::*;
#(
  parameter int NW = 12,
  parameter int AW = 16,
  localparam int LW = NW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] n_div,
  input  logic [AW-1:0] k_frac,
  input  logic          src_sel,
  input  logic          mod_bit,
  output logic          div_clk,
  output logic          div_stb
);
  ctl_src_e      src;
  logic          wrap, carry, adv;
  logic [LW-1:0] base_len, next_len;

  assign src = ctl_src_e'(src_sel);
  assign adv = wrap && (src == CTL_ACCUM);

  fracdiv_accum #(.AW(AW)) u_accum (
    .clk    (clk),
    .rst    (rst),
    .adv    (adv),
    .k_frac (k_frac),
    .carry  (carry)
  );

  fracdiv_select #(.NW(NW)) u_select (
    .n_div     (n_div),
    .src       (src),
    .ext_bit   (mod_bit),
    .acc_carry (carry),
    .base_len  (base_len),
    .next_len  (next_len)
  );

  fracdiv_counter #(.LW(LW)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .base_len (base_len),
    .next_len (next_len),
    .wrap     (wrap),
    .div_clk  (div_clk),
    .div_stb  (div_stb)
  );

  // R3
  len_step_chk: assert property (@(posedge clk) disable iff (rst)
    (next_len == base_len) || (next_len == base_len + LW'(1)));
endmodule

// File: tb/fracdiv_top_test.sv
module fracdiv_top_test;
  localparam int NW = 12;
  localparam int AW = 16;
  localparam longint unsigned MASK = (64'd1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] n_div = NW'(5);
  logic [AW-1:0] k_frac = '0;
  logic          src_sel = 1'b0;
  logic          mod_bit = 1'b0;
  logic          div_clk, div_stb;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int cur_len;
  longint unsigned macc;
  longint unsigned tot;

  always #2 clk = ~clk;

  fracdiv_top #(.NW(NW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .n_div(n_div), .k_frac(k_frac),
    .src_sel(src_sel), .mod_bit(mod_bit),
    .div_clk(div_clk), .div_stb(div_stb)
  );

  function automatic int clampn(int n);
    return (n < 2) ? 2 : n;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog expired act=0 exp=1");
      finish_up();
    end
  end

  // reset, then align to the first strobe (start of period 1)
  task automatic start(int mode, int n, int k, bit b);
    int first;
    longint unsigned sum;
    @(negedge clk);
    rst = 1'b1; src_sel = mode[0]; n_div = NW'(n); k_frac = AW'(k); mod_bit = b;
    repeat (3) @(negedge clk);
    chk(div_stb == 1'b0 && div_clk == 1'b0, "R1 outputs low in reset",
        {div_stb, div_clk}, 0);
    rst = 1'b0;
    first = -1;
    for (int c = 1; c <= clampn(n); c++) begin
      @(negedge clk);
      if (div_stb && first < 0) first = c;
    end
    chk(first == clampn(n), "R1 first strobe after release", first, clampn(n));
    if (mode == 0) begin
      cur_len = clampn(n) + int'(b);
    end else begin
      macc = 0;
      sum = macc + longint'(k);
      cur_len = clampn(n) + int'(sum >> AW);
      macc = sum & MASK;
    end
  endtask

  // walk one period of expected length cur_len, set the next period's inputs
  task automatic one_period(int nn, int nk, int nmode, bit nbit, string tag);
    int hi = 0;
    int bad = 0;
    longint unsigned sum;
    for (int i = 0; i < cur_len; i++) begin
      if (div_stb != (i == 0)) bad++;
      if (div_clk) hi++;
      if (i == 0) begin
        n_div = NW'(nn); k_frac = AW'(nk); src_sel = nmode[0];
      end
      if (i == cur_len - 1) mod_bit = nbit;
      else mod_bit = $urandom % 2;
      @(negedge clk);
    end
    chk(bad == 0, "R6 strobe only on first clock", bad, 0);
    chk(div_stb == 1'b1, tag, div_stb, 1);
    chk(hi == (cur_len + 1) / 2, "R7 high time", hi, (cur_len + 1) / 2);
    tot += longint'(cur_len);
    if (nmode == 0) begin
      cur_len = clampn(nn) + int'(nbit);
    end else begin
      sum = macc + longint'(nk);
      cur_len = clampn(nn) + int'(sum >> AW);
      macc = sum & MASK;
    end
  endtask

  initial begin
    longint unsigned expt;
    int n, k, m;
    void'($urandom(32'd4242));

    // directed: N=2 with both control values, then N below 2
    start(0, 2, 0, 1);
    one_period(2, 0, 0, 0, "R3 period N+1");
    one_period(2, 0, 0, 1, "R2 period N");
    one_period(2, 0, 0, 1, "R3 period N+1");
    one_period(1, 0, 0, 0, "R3 period N+1");
    one_period(0, 0, 0, 1, "R9 clamp period");
    one_period(278, 0, 0, 0, "R9 clamp period N+1");
    one_period(278, 0, 0, 1, "R2 period 278");
    one_period(278, 0, 0, 0, "R3 period 279");
    one_period(5, 0, 0, 0, "R2 period 278");

    // random external stream, N changes at period starts, junk mid-period
    start(0, 9, 0, 0);
    for (int p = 0; p < 1500; p++) begin
      n = 2 + ($urandom % 23);
      one_period(n, 0, 0, $urandom % 2, "R4 R8 sampled control");
    end

    // accumulator 278.3 case
    start(1, 278, 19661, 0);
    tot = 0;
    for (int p = 0; p < 100; p++)
      one_period(278, 19661, 1, $urandom % 2, "R5 accumulator period");
    expt = 100 * 278 + ((100 * 64'd19661) >> AW);
    chk(tot == expt, "R10 total over 100 periods", tot, expt);

    // long accumulator run
    k = 1 + ($urandom % 65535);
    m = 10000;
    start(1, 7, k, 0);
    tot = 0;
    for (int p = 0; p < m; p++)
      one_period(7, k, 1, $urandom % 2, "R5 accumulator period");
    expt = longint'(m) * 7 + ((longint'(m) * longint'(k)) >> AW);
    chk(tot == expt, "R10 total over 10000 periods", tot, expt);
    chk(tot - expt <= 1, "R10 ratio within one count", tot, expt);

    // mixed mode, N and K changes at boundaries
    start(1, 4, 30000, 0);
    for (int p = 0; p < 300; p++) begin
      n = $urandom % 21;
      k = $urandom % 65536;
      one_period(n, k, $urandom % 2, $urandom % 2, "R8 boundary update");
    end

    finish_up();
  end
endmodule